// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a timer with a 16-bit counter. The counter counts in steps of a divided clock. A source selector picks one of several tick inputs. A prescaler then passes every first, second, fourth or eighth tick of that input. In up mode the counter climbs from zero to a programmable limit held in a compare register, then returns to zero, so the limit sets the period. Each period raises two events:

- a compare event, when the counter reaches the limit;
- a rollover event, when the counter returns to zero.

Each event has its own sticky flag and its own enable bit. The gated pair leaves the block as two interrupt request lines for a priority controller.

Software sees the block as four word registers on a simple synchronous write port and a combinational read port. The compare request has a vector of its own. The controller pulses an acknowledge input when it services that vector, and this clears the compare flag. The rollover request shares its vector with other sources, so it stays set until software writes it to zero. A self-clearing clear bit restarts both the counter and the prescaler.

Top module: `tmr_uptimer`

## Requirements
- R1: After synchronous reset, every register reads zero: control (address 0), compare control (address 1), limit (address 2) and count (address 3). Both interrupt lines are low.
- R2: With mode field 1 (up), the count runs 0, 1, …, L and then returns to 0, where L is the limit at address 2. One period is L+1 prescaled ticks.
- R3: The divider field, control bits [3:2], encodes 0, 1, 2 and 3 as one count step per 1, 2, 4 and 8 selected source ticks.
- R4: The source field, control bits [1:0], picks `tick_src_i[n]`. Only high cycles of the picked input feed the prescaler. A value of N_SRC or more feeds nothing.
- R5: Writing control bit 6 as 1 zeroes the count and the prescaler on that edge. Bit 6 always reads back as 0.
- R6: Mode field values 0, 2 and 3 (control bits [5:4]) hold the count, the prescaler and both flags.
- R7: The compare flag (address 1, bit 1) sets on the edge where the count steps onto the limit.
- R8: The rollover flag (control bit 8) sets on the edge where the count returns from the limit to 0.
- R9: `irq_cmp_o` is high exactly while the compare flag and the compare enable (address 1, bit 0) are both 1.
- R10: `irq_ovf_o` is high exactly while the rollover flag and the rollover enable (control bit 7) are both 1.
- R11: A `cmp_ack_i` pulse clears the compare flag. It has no effect on the rollover flag, which changes only through a control write or a rollover. When the hardware sets a flag in the same cycle, the set wins. A register write to address 1 wins over the acknowledge.
- R12: Writes to address 3 are ignored. Address 3 reads the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_src_i | input | N_SRC | Candidate count sources, one per bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write register address |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 2 | Read register address |
| rd_data_o | output | CNT_W | Combinational read data |
| cmp_ack_i | input | 1 | Compare vector acknowledge |
| irq_cmp_o | output | 1 | Compare interrupt request |
| irq_ovf_o | output | 1 | Rollover interrupt request |

## Verification
The bench builds the block with its defaults: CNT_W of 16 and N_SRC of 2.

- Source 0 is tied high, so it exercises free-running counting.
- Source 1 toggles at random, so it exercises gated counting.
- Source codes 2 and 3 fall past N_SRC and exercise the no-source case.

Random limits are drawn from 0 to 15. With a 16-bit counter, this makes wraps, the limit-zero case and a limit written below the running count occur many times within a short run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_STOP = 2'd0,
        MODE_UP   = 2'd1,
        MODE_RSV2 = 2'd2,
        MODE_RSV3 = 2'd3
    } mode_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_CCTL  = 2'd1;
    localparam logic [1:0] ADDR_LIMIT = 2'd2;
    localparam logic [1:0] ADDR_COUNT = 2'd3;

    localparam int CLR_BIT     = 6;
    localparam int OVF_IE_BIT  = 7;
    localparam int OVF_FLG_BIT = 8;
    localparam int CMP_IE_BIT  = 0;
    localparam int CMP_FLG_BIT = 1;

    typedef struct packed {
        logic       ovf_flag;
        logic       ovf_ie;
        mode_e      mode;
        logic [1:0] div;
        logic [1:0] src;
    } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int N_SRC = 2,
    parameter int DIV_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_SRC-1:0] src_i,
    input  logic [1:0]       sel_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             run_i,
    input  logic             clr_i,
    output logic             tick_o
);
    localparam int PS_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [PS_W-1:0] pcnt;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic src_hit;
    logic [PS_W-1:0] lim;

    always_comb begin
        src_hit = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel_i == 2'(i)) src_hit = src_i[i];
        end
    end

    always_comb begin
        lim    = (PS_W'(1) << div_i) - PS_W'(1);
        st_d   = st_q;
        tick_o = 1'b0;
        if (clr_i) begin
            st_d.pcnt = '0;
        end else if (run_i && src_hit) begin
            if (st_q.pcnt >= lim) begin
                st_d.pcnt = '0;
                tick_o    = 1'b1;
            end else begin
                st_d.pcnt = st_q.pcnt + PS_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    // R5: a clear restarts the prescaler
    p_clr_prescale_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> st_q.pcnt == '0);
    // R6: without a running source tick the prescaler holds
    p_ps_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!run_i && !clr_i) |=> $stable(st_q.pcnt));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        hit_o  = 1'b0;
        wrap_o = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            wrap_o   = (st_q.cnt == cmp_i);
            st_d.cnt = wrap_o ? '0 : st_q.cnt + CNT_W'(1);
            hit_o    = (st_d.cnt == cmp_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R2/R8: a tick at the limit returns the count to zero
    p_wrap_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && !clr_i && st_q.cnt == cmp_i) |=> st_q.cnt == '0);
    // R6: no tick and no clear keeps the count
    p_cnt_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && !clr_i) |=> $stable(st_q.cnt));
endmodule

// File: rtl/tmr_uptimer.sv
module tmr_uptimer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_SRC = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_SRC-1:0] tick_src_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [CNT_W-1:0] rd_data_o,
    input  logic             cmp_ack_i,
    output logic             irq_cmp_o,
    output logic             irq_ovf_o
);
    localparam int DIV_W  = 2;
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             cmp_ie;
        logic             cmp_flag;
        logic [CNT_W-1:0] limit;
    } regs_t;

    regs_t r_d, r_q;
    logic wr_ctrl, wr_cctl, wr_lim, clr, run, tick, hit, wrap;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
        wr_cctl = wr_en_i && (wr_addr_i == ADDR_CCTL);
        wr_lim  = wr_en_i && (wr_addr_i == ADDR_LIMIT);
        clr     = wr_ctrl && wr_data_i[CLR_BIT];
        run     = (r_q.ctrl.mode == MODE_UP);
    end

    tmr_prescaler #(.N_SRC(N_SRC), .DIV_W(DIV_W)) u_ps (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .src_i  (tick_src_i),
        .sel_i  (r_q.ctrl.src),
        .div_i  (r_q.ctrl.div),
        .run_i  (run),
        .clr_i  (clr),
        .tick_o (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick),
        .clr_i  (clr),
        .cmp_i  (r_q.limit),
        .cnt_o  (cnt),
        .hit_o  (hit),
        .wrap_o (wrap)
    );

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.ctrl.src    = wr_data_i[1:0];
            r_d.ctrl.div    = wr_data_i[3:2];
            r_d.ctrl.mode   = mode_e'(wr_data_i[5:4]);
            r_d.ctrl.ovf_ie = wr_data_i[OVF_IE_BIT];
            r_d.ctrl.ovf_flag = wr_data_i[OVF_FLG_BIT];
        end
        if (wrap) r_d.ctrl.ovf_flag = 1'b1;

        if (wr_cctl) begin
            r_d.cmp_ie   = wr_data_i[CMP_IE_BIT];
            r_d.cmp_flag = wr_data_i[CMP_FLG_BIT];
        end else if (cmp_ack_i) begin
            r_d.cmp_flag = 1'b0;
        end
        if (hit) r_d.cmp_flag = 1'b1;

        if (wr_lim) r_d.limit = wr_data_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q <= '0;
        else       r_q <= r_d;
    end

    always_comb begin
        case (rd_addr_i)
            ADDR_CTRL:  rd_data_o = CNT_W'({r_q.ctrl.ovf_flag, r_q.ctrl.ovf_ie, 1'b0,
                                            r_q.ctrl.mode, r_q.ctrl.div, r_q.ctrl.src});
            ADDR_CCTL:  rd_data_o = CNT_W'({r_q.cmp_flag, r_q.cmp_ie});
            ADDR_LIMIT: rd_data_o = r_q.limit;
            default:    rd_data_o = cnt;
        endcase
    end

    assign irq_cmp_o = r_q.cmp_flag & r_q.cmp_ie;
    assign irq_ovf_o = r_q.ctrl.ovf_flag & r_q.ctrl.ovf_ie;

    initial begin
        assert (CNT_W >= CTRL_W + 1) else $error("CNT_W too narrow for control word");
        assert (N_SRC >= 1 && N_SRC <= 4) else $error("N_SRC out of range");
    end

    // R11: an acknowledge alone clears the compare flag
    p_ack_clears_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmp_ack_i && !wr_cctl && !hit) |=> !r_q.cmp_flag);
    // R11: the rollover flag survives anything but a control write
    p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.ctrl.ovf_flag && !wr_ctrl) |=> r_q.ctrl.ovf_flag);
    // R6: outside up mode the count does not move without a clear
    p_stop_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!run && !clr) |=> $stable(cnt));
    // R7: the compare flag rises only with the count at the limit
    p_cmp_rise_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!r_q.cmp_flag && !wr_cctl && !wr_lim && hit) |=> (r_q.cmp_flag && cnt == r_q.limit));
endmodule

// File: tb/tmr_uptimer_tb_top.sv
module tmr_uptimer_tb_top;
    localparam int CNT_W = 16;
    localparam int N_SRC = 2;

    logic             clk = 1'b0;
    logic             rst_i = 1'b1;
    logic [N_SRC-1:0] tick_src_i = '0;
    logic             wr_en_i = 1'b0;
    logic [1:0]       wr_addr_i = '0;
    logic [CNT_W-1:0] wr_data_i = '0;
    logic [1:0]       rd_addr_i = '0;
    logic [CNT_W-1:0] rd_data_o;
    logic             cmp_ack_i = 1'b0;
    logic             irq_cmp_o, irq_ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    tmr_uptimer #(.CNT_W(CNT_W), .N_SRC(N_SRC)) dut_i (
        .clk_i(clk), .rst_i(rst_i), .tick_src_i(tick_src_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .cmp_ack_i(cmp_ack_i),
        .irq_cmp_o(irq_cmp_o), .irq_ovf_o(irq_ovf_o)
    );

    // reference state, built from the requirements
    logic [1:0]  m_src, m_div, m_mode;
    logic        m_ovf_ie, m_ovf, m_cie, m_cf;
    logic [15:0] m_lim, m_cnt;
    logic [2:0]  m_pc;

    task automatic model_reset();
        m_src = 0; m_div = 0; m_mode = 0; m_ovf_ie = 0; m_ovf = 0;
        m_cie = 0; m_cf = 0; m_lim = 0; m_cnt = 0; m_pc = 0;
    endtask

    function automatic logic [15:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {7'd0, m_ovf, m_ovf_ie, 1'b0, m_mode, m_div, m_src};
            2'd1:    return {14'd0, m_cf, m_cie};
            2'd2:    return m_lim;
            default: return m_cnt;
        endcase
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input logic we, input logic [1:0] wa, input logic [15:0] wd,
                        input logic ack, input logic s1, input logic [1:0] ra);
        logic clr, hit_src, tick, wrap, hit;
        logic [2:0] lim;
        logic [15:0] nc;
        wr_en_i = we; wr_addr_i = wa; wr_data_i = wd; cmp_ack_i = ack;
        tick_src_i = {s1, 1'b1}; rd_addr_i = ra;
        #1;
        case (ra)
            2'd0:    chk(rd_data_o, exp_read(ra), "R5,R8,R10 control read");
            2'd1:    chk(rd_data_o, exp_read(ra), "R7,R9,R11 compare control read");
            2'd2:    chk(rd_data_o, exp_read(ra), "R2 limit read");
            default: chk(rd_data_o, exp_read(ra), "R2,R3,R4,R6,R12 count read");
        endcase
        chk({15'd0, irq_cmp_o}, {15'd0, m_cf & m_cie}, "R9 compare request");
        chk({15'd0, irq_ovf_o}, {15'd0, m_ovf & m_ovf_ie}, "R10 rollover request");
        // next state at the coming edge
        clr = we && wa == 2'd0 && wd[6];
        hit_src = (m_src == 2'd0) ? 1'b1 : (m_src == 2'd1) ? s1 : 1'b0;
        lim = 3'((4'd1 << m_div) - 4'd1);
        tick = 1'b0;
        if (clr) m_pc = 0;
        else if (m_mode == 2'd1 && hit_src) begin
            if (m_pc >= lim) begin m_pc = 0; tick = 1'b1; end
            else m_pc = m_pc + 3'd1;
        end
        wrap = tick && (m_cnt == m_lim);
        nc = clr ? 16'd0 : tick ? (wrap ? 16'd0 : m_cnt + 16'd1) : m_cnt;
        hit = tick && (nc == m_lim);
        if (we && wa == 2'd0) begin
            m_src = wd[1:0]; m_div = wd[3:2]; m_mode = wd[5:4];
            m_ovf_ie = wd[7]; m_ovf = wd[8];
        end
        if (wrap) m_ovf = 1'b1;
        if (we && wa == 2'd1) begin m_cie = wd[0]; m_cf = wd[1]; end
        else if (ack) m_cf = 1'b0;
        if (hit) m_cf = 1'b1;
        if (we && wa == 2'd2) m_lim = wd;
        m_cnt = nc;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic [1:0] ra);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 16'd0, 1'b0, 1'($urandom % 2), ra);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: all requirements, actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_i = 1'b0;
        // R1: reset values
        for (int a = 0; a < 4; a++) begin
            rd_addr_i = 2'(a);
            #1;
            chk(rd_data_o, 16'd0, "R1 reset register value");
        end
        chk({14'd0, irq_ovf_o, irq_cmp_o}, 16'd0, "R1 reset requests");
        @(negedge clk);

        // R2, R7, R8: limit 4, divide 1, source 0
        step(1'b1, 2'd2, 16'd4, 1'b0, 1'b0, 2'd3);
        step(1'b1, 2'd1, 16'd1, 1'b0, 1'b0, 2'd3);
        step(1'b1, 2'd0, 16'h0090, 1'b0, 1'b0, 2'd3);
        idle(12, 2'd3);
        // R11: acknowledge clears compare, rollover stays
        step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 2'd1);
        step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 2'd0);
        // R3, R5: divide by 8 with clear, limit 9
        step(1'b1, 2'd2, 16'd9, 1'b0, 1'b0, 2'd3);
        step(1'b1, 2'd0, 16'h00DC, 1'b0, 1'b0, 2'd0);
        idle(170, 2'd3);
        // R4: gated source 1, divide 2
        step(1'b1, 2'd0, 16'h0095, 1'b0, 1'b0, 2'd3);
        idle(60, 2'd3);
        // R4: source code past N_SRC
        step(1'b1, 2'd0, 16'h0092, 1'b0, 1'b0, 2'd3);
        idle(20, 2'd3);
        // R6: stop and reserved modes hold
        step(1'b1, 2'd0, 16'h0080, 1'b0, 1'b0, 2'd3);
        idle(20, 2'd3);
        step(1'b1, 2'd0, 16'h01A0, 1'b0, 1'b0, 2'd0);
        idle(20, 2'd3);
        step(1'b1, 2'd0, 16'h00B0, 1'b0, 1'b0, 2'd3);
        idle(10, 2'd3);
        // R12: write to count ignored
        step(1'b1, 2'd3, 16'h1234, 1'b0, 1'b0, 2'd3);
        step(1'b0, 2'd0, 16'd0, 1'b0, 1'b0, 2'd3);
        // R1.. random mix
        for (int i = 0; i < 30000; i++) begin
            logic we;
            logic [1:0] wa;
            logic [15:0] wd;
            we = ($urandom % 12) == 0;
            wa = 2'($urandom % 4);
            wd = 16'($urandom);
            if (wa == 2'd2) wd = 16'($urandom % 16);
            if (wa == 2'd0) begin
                wd = wd & 16'h01FF;
                if ($urandom % 5 != 0) wd[5:4] = 2'd1;
                if ($urandom % 4 != 0) wd[6] = 1'b0;
            end
            step(we, wa, wd, ($urandom % 8) == 0, 1'($urandom % 2), 2'($urandom % 4));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule